// File: doc/BRIEF.md
# Bypass Protection Trip Latch

This block holds the gate command for the bypass switches that shield a series-injected inverter. It must always offer a current path. Any hardware fault sets the latch at once, with no software involvement. Once set, the latch stays set until the supervising controller explicitly clears it. Hardware inputs can only set the latch, never clear it. The controller can also trip the latch itself, or hold it forced on so that a reset request is refused.

The block has two kinds of fault input:
- Overcurrent flags, one per phase, already arrive synchronous to the clock and act on the next edge.
- Desaturation and thermal fault lines are asynchronous. Each passes through a two-flop synchronizer and then a two-cycle agreement filter before it can trip the latch. A single-cycle glitch is therefore rejected.

A sticky cause register records every source that contributed while the latch was set. A one-cycle interrupt marks each clear-to-set transition. All pins are plain control and status levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `prot_trip_latch`

## Requirements
- R1: A high level on any phase overcurrent flag sampled at a rising edge makes `bypass_en_o` 1 after that same edge. It also sets the cause bit whose index equals the phase number (bits 0..2).
- R2: A desaturation or thermal input held high from before rising edge k makes `bypass_en_o` 1 after edge k+3. The same input high for only one clock period never sets the latch.
- R3: Deasserting every hardware fault input never clears `bypass_en_o` or any cause bit.
- R4: With no set source active, `ctl_reset_i` sampled high clears `bypass_en_o` and the whole cause register after that edge.
- R5: `ctl_set_i` sampled high sets `bypass_en_o` and cause bit 5 (controller).
- R6: While `ctl_hold_i` is high, the latch is set, cause bit 5 is set, and `ctl_reset_i` has no effect.
- R7: When a hardware set source and `ctl_reset_i` are both active at the same edge, the latch ends up set.
- R8: While the latch is set, each newly active source ORs its cause bit into the register. Bit 3 is desaturation and bit 4 is thermal. Earlier bits are kept.
- R9: `trip_irq_o` is 1 for exactly the one cycle in which `bypass_en_o` first reads 1 after reading 0. It is 0 at all other times.
- R10: After `rst_n` is released, `bypass_en_o` is 1, `trip_cause_o` is 0 and `trip_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the latch comes up set |
| oc_flag_i | input | 3 | Per-phase overcurrent comparator flags, synchronous |
| desat_flt_i | input | 1 | Asynchronous desaturation fault |
| therm_flt_i | input | 1 | Asynchronous thermal fault |
| ctl_set_i | input | 1 | Controller trip strobe |
| ctl_hold_i | input | 1 | Controller hold-on level |
| ctl_reset_i | input | 1 | Controller clear strobe |
| bypass_en_o | output | 1 | Bypass gate enable (latch state) |
| trip_cause_o | output | 6 | Sticky cause bits: phase 0..2, desat, thermal, controller |
| trip_irq_o | output | 1 | One-cycle pulse on latch clear-to-set |

## Verification
The hardest situation to reach is a filtered asynchronous fault that becomes valid on the very edge where a controller reset or hold change arrives. The filter delay hides the moment of acceptance from the ports. To reach it, the bench keeps a cycle-accurate model of the synchronizer and agreement window. It advances that model on every edge it drives, so it knows exactly which edge accepts the fault. It then lines up clears, holds and same-cycle set/reset collisions against those edges. Single-cycle pulses on the asynchronous lines are also driven to show that the filter rejects them.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  localparam int EXTRA_SRCS = 3;

  function automatic int desat_bit(input int nph);
    return nph;
  endfunction

  function automatic int therm_bit(input int nph);
    return nph + 1;
  endfunction

  function automatic int ctl_bit(input int nph);
    return nph + 2;
  endfunction
endpackage

// File: rtl/ptl_sync_filter.sv
module ptl_sync_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int AGREE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic ok_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
  end

  generate
    if (AGREE_CYCLES > 1) begin : g_agree
      logic [AGREE_CYCLES-2:0] hist_q;
      logic [AGREE_CYCLES-1:0] win;
      assign win = {hist_q, sync_q[TOP]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= win[AGREE_CYCLES-2:0];
      end

      assign ok_o = &win;

      // R2
      filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(sync_q[TOP]));
    end else begin : g_direct
      assign ok_o = sync_q[TOP];
    end
  endgenerate
endmodule

// File: rtl/ptl_latch_core.sv
module ptl_latch_core #(
  parameter int HW_SRCS = 5,
  localparam int CAUSE_W = HW_SRCS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HW_SRCS-1:0] hw_src_i,
  input  logic               sw_set_i,
  input  logic               sw_hold_i,
  input  logic               sw_reset_i,
  output logic               latch_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic               latch_q, latch_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               irq_q;
  logic [CAUSE_W-1:0] src_vec;
  logic               any_set;

  assign src_vec = {sw_set_i | sw_hold_i, hw_src_i};
  assign any_set = |src_vec;

  always_comb begin
    latch_d = latch_q;
    cause_d = cause_q;
    if (any_set) begin
      latch_d = 1'b1;
      cause_d = cause_q | src_vec;
    end else if (sw_reset_i) begin
      latch_d = 1'b0;
      cause_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      cause_q <= cause_d;
      irq_q   <= latch_d & ~latch_q;
    end
  end

  assign latch_o = latch_q;
  assign cause_o = cause_q;
  assign irq_o   = irq_q;

  // R4
  clear_by_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> $past(sw_reset_i));

  // R6
  hold_keeps_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hold_i |=> latch_q);

  // R7
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_src_i) |=> latch_q);

  // R9
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (latch_q && !$past(latch_q)));

  // R8
  cause_with_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q |-> (cause_q == '0));
endmodule

// File: rtl/prot_trip_latch.sv
module prot_trip_latch #(
  parameter int NUM_PHASES   = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int AGREE_CYCLES = 2,
  localparam int HW_SRCS = NUM_PHASES + 2,
  localparam int CAUSE_W = NUM_PHASES + ptl_pkg::EXTRA_SRCS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] oc_flag_i,
  input  logic                  desat_flt_i,
  input  logic                  therm_flt_i,
  input  logic                  ctl_set_i,
  input  logic                  ctl_hold_i,
  input  logic                  ctl_reset_i,
  output logic                  bypass_en_o,
  output logic [CAUSE_W-1:0]    trip_cause_o,
  output logic                  trip_irq_o
);
  localparam int N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_raw;
  logic [N_ASYNC-1:0] async_ok;
  logic [HW_SRCS-1:0] hw_src;

  assign async_raw = {therm_flt_i, desat_flt_i};

  generate
    for (genvar g = 0; g < N_ASYNC; g++) begin : g_async
      ptl_sync_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .AGREE_CYCLES(AGREE_CYCLES)
      ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(async_raw[g]),
        .ok_o   (async_ok[g])
      );
    end
  endgenerate

  assign hw_src = {async_ok, oc_flag_i};

  ptl_latch_core #(.HW_SRCS(HW_SRCS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_src_i  (hw_src),
    .sw_set_i  (ctl_set_i),
    .sw_hold_i (ctl_hold_i),
    .sw_reset_i(ctl_reset_i),
    .latch_o   (bypass_en_o),
    .cause_o   (trip_cause_o),
    .irq_o     (trip_irq_o)
  );

  // R1
  oc_sets_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_flag_i) |=> (bypass_en_o && (trip_cause_o[NUM_PHASES-1:0] != '0)));

  // R5
  ctl_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set_i |=> (bypass_en_o && trip_cause_o[ptl_pkg::ctl_bit(NUM_PHASES)]));

  // R3
  hw_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en_o && !ctl_reset_i) |=> bypass_en_o);
endmodule

// File: tb/prot_trip_latch_bench.sv
module prot_trip_latch_bench;
  localparam int NPH = 3;
  localparam int CW  = NPH + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPH-1:0] oc = '0;
  logic desat = 1'b0, therm = 1'b0, cset = 1'b0, chold = 1'b0, creset = 1'b0;
  logic bypass, irq;
  logic [CW-1:0] cause;

  always #2 clk = ~clk;

  prot_trip_latch u_prot_trip_latch (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc), .desat_flt_i(desat),
    .therm_flt_i(therm), .ctl_set_i(cset), .ctl_hold_i(chold),
    .ctl_reset_i(creset), .bypass_en_o(bypass), .trip_cause_o(cause),
    .trip_irq_o(irq)
  );

  typedef struct {
    logic          b;
    logic [CW-1:0] c;
    logic          i;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic m_latch = 1'b1;
  logic [CW-1:0] m_cause = '0;
  logic [2:0] d_pipe = '0, t_pipe = '0;  // {agree, sync2, sync1}

  task automatic cyc(input logic [NPH-1:0] o, input logic d, input logic t,
                     input logic s, input logic h, input logic r, input string tag);
    logic d_ok, t_ok, nl;
    logic [CW-1:0] src, nc;
    exp_t e;
    oc = o; desat = d; therm = t; cset = s; chold = h; creset = r;
    d_ok = d_pipe[1] & d_pipe[2];
    t_ok = t_pipe[1] & t_pipe[2];
    src  = {s | h, t_ok, d_ok, o};
    if (src != '0) begin nl = 1'b1; nc = m_cause | src; end
    else if (r)    begin nl = 1'b0; nc = '0; end
    else           begin nl = m_latch; nc = m_cause; end
    e.b = nl; e.c = nc; e.i = nl & ~m_latch; e.tag = tag;
    exp_q.push_back(e);
    m_latch = nl; m_cause = nc;
    d_pipe = {d_pipe[1], d_pipe[0], d};
    t_pipe = {t_pipe[1], t_pipe[0], t};
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc('0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (bypass !== e.b || cause !== e.c || irq !== e.i) begin
          fails++;
          $display("FAIL %s: bypass=%0b cause=%b irq=%0b expected bypass=%0b cause=%b irq=%0b",
                   e.tag, bypass, cause, irq, e.b, e.c, e.i);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    checks++;
    if (bypass !== 1'b1 || cause !== '0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R10: bypass=%0b cause=%b irq=%0b expected 1 000000 0", bypass, cause, irq);
    end
    idle(2, "R10");
    cyc('0, 0, 0, 0, 0, 1, "R4");
    idle(2, "R4");
    cyc(3'b010, 0, 0, 0, 0, 0, "R1");
    idle(3, "R9 R3");
    cyc('0, 0, 0, 0, 0, 1, "R4");
    cyc('0, 1, 0, 0, 0, 0, "R2 glitch");
    idle(6, "R2 glitch");
    cyc('0, 0, 1, 0, 0, 0, "R2 glitch");
    idle(6, "R2 glitch");
    for (int k = 0; k < 6; k++) cyc('0, 1, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 5; k++) cyc('0, 1, 1, 0, 0, 0, "R8");
    cyc(3'b001, 1, 1, 0, 0, 0, "R8");
    idle(5, "R3");
    cyc('0, 0, 0, 0, 0, 1, "R4");
    // filtered fault accepted on the same edge as a reset
    for (int k = 0; k < 3; k++) cyc('0, 0, 1, 0, 0, 0, "R2");
    cyc('0, 0, 1, 0, 0, 1, "R7");
    idle(4, "R7");
    cyc('0, 0, 0, 0, 0, 1, "R4");
    cyc('0, 0, 0, 0, 1, 0, "R6");
    cyc('0, 0, 0, 0, 1, 1, "R6");
    cyc('0, 0, 0, 0, 1, 1, "R6");
    cyc('0, 0, 0, 0, 0, 1, "R6");
    idle(2, "R6");
    cyc('0, 0, 0, 1, 0, 0, "R5");
    idle(2, "R5");
    cyc('0, 0, 0, 0, 0, 1, "R4");
    cyc(3'b001, 0, 0, 0, 0, 1, "R7");
    cyc(3'b100, 0, 0, 0, 0, 1, "R7");
    idle(2, "R7");
    cyc('0, 0, 0, 0, 0, 1, "R4");
    idle(3, "R4");
    @(posedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule